// File: doc/BRIEF.md
# Rank Chip-Select Decoder with Interleave Modes

This block turns a request address into the four active-high DRAM rank selects. Each rank has a start register and an end+1 (limit) register. A 4-bit mode input sets how the ranks are chosen. In the plain mode every rank is picked by range compare alone. In the fully interleaved mode two address bits choose the rank. In three mixed modes, two adjacent ranks share one range and one address bit splits them, while the other two ranks keep their own range compare. A bit-position input holds two bit indices that name the address bits used for interleaving.

The request is sampled on a strobe. The selects, an error flag and a valid flag are registered, so they appear one clock after the strobe. An unknown mode drives no select and raises the error flag. The block has no storage beyond that one output stage.

Top module: `rank_select_decoder`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. After a cycle with `req_valid` low, `out_valid`, `cs_out` and `mode_err` are all zero.
- R2: Rank i hits its range when start_i <= address < limit_i. An address equal to start hits. An address equal to limit does not.
- R3: Mode 4'b0000 selects each rank by its own range compare. Where ranges overlap, the lowest-numbered hitting rank wins.
- R4: Mode 4'b1111 uses the range of rank 0 for all four ranks. On a hit, it selects rank number {address[high index], address[low index]}. On a miss, it selects none.
- R5: Mode 4'b1100 range-decodes ranks 0 and 1, and splits ranks 2 and 3 on the low-index address bit.
- R6: Mode 4'b0110 range-decodes ranks 0 and 3, and splits ranks 1 and 2 on the low-index address bit.
- R7: Mode 4'b0011 range-decodes ranks 2 and 3, and splits ranks 0 and 1 on the low-index address bit.
- R8: An interleaved pair is tested against the range registers of its lower-numbered rank. An interleave bit of 0 picks the lower-numbered rank and 1 picks the higher. The range registers of the higher rank of a pair are ignored.
- R9: Any other mode value sets `mode_err` and drives all selects low. A valid mode clears `mode_err`.
- R10: `cs_out` is always one-hot or all zero.
- R11: While reset is active and after it releases, all outputs are zero until the first request.
- R12: A bit index at or beyond the address width reads as bit value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Request address |
| mode | input | 4 | Selection mode |
| start_flat | input | 4*ADDR_W | Start address per rank; rank i at bits [i*ADDR_W +: ADDR_W] |
| limit_flat | input | 4*ADDR_W | End+1 address per rank, same packing |
| ilv_pos | input | 2*IDX_W | Low bit index in [IDX_W-1:0], high bit index in [2*IDX_W-1:IDX_W] |
| out_valid | output | 1 | Registered result valid |
| cs_out | output | 4 | Registered rank selects, active high |
| mode_err | output | 1 | Registered unknown-mode flag |

## Verification
A wrong pair mapping or a swapped interleave bit shows up as the wrong select bit one clock after the strobe. The same happens when a rank is range-decoded that should be split by a bit. An off-by-one in the range compare shows only at the start and limit addresses, so those exact values are driven. A stale output register shows up as a select or error flag that stays set in the idle cycle after a request.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
   localparam int RSD_NCS = 4;
   typedef enum logic [3:0] {
      MODE_RANGE    = 4'b0000,
      MODE_FULL     = 4'b1111,
      MODE_HI_PAIR  = 4'b1100,
      MODE_MID_PAIR = 4'b0110,
      MODE_LO_PAIR  = 4'b0011
   } rsd_mode_e;
endpackage

// File: rtl/rsd_range_bank.sv
module rsd_range_bank #(
   parameter int ADDR_W = 36,
   parameter int NCS    = 4
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [NCS*ADDR_W-1:0] lo_flat,
   input  logic [NCS*ADDR_W-1:0] hi_flat,
   output logic [NCS-1:0]        hit
);
   // One compare pair per rank: start inclusive, end+1 exclusive (R2)
   for (genvar i = 0; i < NCS; i++) begin : g_cmp
      logic [ADDR_W-1:0] lo_i, hi_i;
      assign lo_i   = lo_flat[i*ADDR_W +: ADDR_W];
      assign hi_i   = hi_flat[i*ADDR_W +: ADDR_W];
      assign hit[i] = (addr >= lo_i) && (addr < hi_i);
   end
endmodule

// File: rtl/rsd_bit_pick.sv
module rsd_bit_pick #(
   parameter int ADDR_W = 36,
   parameter int IDX_W  = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [IDX_W-1:0]  idx,
   output logic              bit_o
);
   // A shift by an index past the width leaves zero, giving R12
   logic [ADDR_W-1:0] shifted;
   assign shifted = addr >> idx;
   assign bit_o   = shifted[0];
endmodule

// File: rtl/rsd_select.sv
module rsd_select
   import rsd_pkg::*;
(
   input  logic [3:0] mode,
   input  logic [3:0] hit,
   input  logic       b_lo,
   input  logic       b_hi,
   output logic [3:0] cs,
   output logic       err
);
   logic [3:0] cand;

   always_comb begin
      err  = 1'b0;
      cand = 4'b0000;
      case (mode)
         MODE_RANGE:    cand = hit;
         MODE_FULL:     cand = hit[0] ? (4'b0001 << {b_hi, b_lo}) : 4'b0000;
         MODE_HI_PAIR:  cand = {hit[2] & b_lo, hit[2] & ~b_lo, hit[1], hit[0]};
         MODE_MID_PAIR: cand = {hit[3], hit[1] & b_lo, hit[1] & ~b_lo, hit[0]};
         MODE_LO_PAIR:  cand = {hit[3], hit[2], hit[0] & b_lo, hit[0] & ~b_lo};
         default:       err  = 1'b1;
      endcase
   end

   // Keep the lowest set candidate so overlapping ranges stay one-hot
   assign cs = cand & (~cand + 4'b0001);
endmodule

// File: rtl/rank_select_decoder.sv
module rank_select_decoder
   import rsd_pkg::*;
#(
   parameter int ADDR_W = 36,
   parameter int IDX_W  = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [3:0]                mode,
   input  logic [RSD_NCS*ADDR_W-1:0] start_flat,
   input  logic [RSD_NCS*ADDR_W-1:0] limit_flat,
   input  logic [2*IDX_W-1:0]        ilv_pos,
   output logic                      out_valid,
   output logic [RSD_NCS-1:0]        cs_out,
   output logic                      mode_err
);
   localparam int IDX_SPAN = 1 << IDX_W;

   if (ADDR_W < 2)  begin : g_bad_aw  $error("ADDR_W must be at least 2"); end
   if (IDX_W < 1 || IDX_W > 16) begin : g_bad_iw  $error("IDX_W out of range"); end
   if (IDX_SPAN < 2) begin : g_bad_span $error("index span too small"); end

   logic [RSD_NCS-1:0] hit, cs_next;
   logic               b_lo, b_hi, err_next;

   rsd_range_bank #(.ADDR_W(ADDR_W), .NCS(RSD_NCS)) u_bank (
      .addr(req_addr), .lo_flat(start_flat), .hi_flat(limit_flat), .hit(hit)
   );

   rsd_bit_pick #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick_lo (
      .addr(req_addr), .idx(ilv_pos[IDX_W-1:0]), .bit_o(b_lo)
   );

   rsd_bit_pick #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick_hi (
      .addr(req_addr), .idx(ilv_pos[2*IDX_W-1:IDX_W]), .bit_o(b_hi)
   );

   rsd_select u_sel (
      .mode(mode), .hit(hit), .b_lo(b_lo), .b_hi(b_hi),
      .cs(cs_next), .err(err_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         cs_out    <= '0;
         mode_err  <= 1'b0;
      end else begin
         out_valid <= req_valid;
         cs_out    <= req_valid ? cs_next : '0;
         mode_err  <= req_valid & err_next;
      end
   end
endmodule

// File: rtl/rank_select_decoder_chk.sv
module rank_select_decoder_chk #(
   parameter int ADDR_W = 36,
   parameter int IDX_W  = 6
) (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [3:0]  mode,
   input logic        out_valid,
   input logic [3:0]  cs_out,
   input logic        mode_err
);
   logic known_mode;
   assign known_mode = (mode == 4'b0000) || (mode == 4'b1111) || (mode == 4'b1100)
                    || (mode == 4'b0110) || (mode == 4'b0011);

   assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_out));

   assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> (cs_out == 4'b0000));

   assert_bad_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !known_mode) |=> mode_err);

   assert_good_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && known_mode) |=> !mode_err);

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && cs_out == 4'b0000 && !mode_err));
endmodule

bind rank_select_decoder rank_select_decoder_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
   .out_valid(out_valid), .cs_out(cs_out), .mode_err(mode_err)
);

// File: tb/rank_select_decoder_test.sv
`timescale 1ns/1ps
module rank_select_decoder_test;
   localparam int AW = 36;
   localparam int IW = 6;
   localparam int NV = 28;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic [3:0]      mode = 4'b0000;
   logic [4*AW-1:0] start_flat = '0;
   logic [4*AW-1:0] limit_flat = '0;
   logic [2*IW-1:0] ilv_pos = '0;
   logic            out_valid;
   logic [3:0]      cs_out;
   logic            mode_err;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   rank_select_decoder #(.ADDR_W(AW), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .mode(mode), .start_flat(start_flat), .limit_flat(limit_flat),
      .ilv_pos(ilv_pos), .out_valid(out_valid), .cs_out(cs_out), .mode_err(mode_err)
   );

   // {mode, addr[11:0], expected cs, expected err}; ranges 0x000/0x100/0x200/0x300 wide 0x100
   localparam logic [20:0] VEC [0:NV-1] = '{
      {4'b0000, 12'h000, 4'b0001, 1'b0},  // R2 start inclusive
      {4'b0000, 12'h0FF, 4'b0001, 1'b0},
      {4'b0000, 12'h100, 4'b0010, 1'b0},  // R2 limit exclusive
      {4'b0000, 12'h250, 4'b0100, 1'b0},
      {4'b0000, 12'h3FF, 4'b1000, 1'b0},
      {4'b0000, 12'h400, 4'b0000, 1'b0},  // R2 miss past last limit
      {4'b1111, 12'h030, 4'b1000, 1'b0},
      {4'b1111, 12'h010, 4'b0010, 1'b0},
      {4'b1111, 12'h020, 4'b0100, 1'b0},
      {4'b1111, 12'h000, 4'b0001, 1'b0},
      {4'b1111, 12'h150, 4'b0000, 1'b0},
      {4'b1100, 12'h050, 4'b0001, 1'b0},
      {4'b1100, 12'h150, 4'b0010, 1'b0},
      {4'b1100, 12'h200, 4'b0100, 1'b0},  // R8 bit 0 -> lower
      {4'b1100, 12'h210, 4'b1000, 1'b0},  // R8 bit 1 -> higher
      {4'b1100, 12'h350, 4'b0000, 1'b0},  // R8 rank 3 range ignored
      {4'b0110, 12'h050, 4'b0001, 1'b0},
      {4'b0110, 12'h350, 4'b1000, 1'b0},
      {4'b0110, 12'h110, 4'b0100, 1'b0},
      {4'b0110, 12'h100, 4'b0010, 1'b0},
      {4'b0110, 12'h250, 4'b0000, 1'b0},  // R8 rank 2 range ignored
      {4'b0011, 12'h000, 4'b0001, 1'b0},
      {4'b0011, 12'h010, 4'b0010, 1'b0},
      {4'b0011, 12'h150, 4'b0000, 1'b0},  // R8 rank 1 range ignored
      {4'b0011, 12'h250, 4'b0100, 1'b0},
      {4'b0011, 12'h350, 4'b1000, 1'b0},
      {4'b0101, 12'h050, 4'b0000, 1'b1},
      {4'b1000, 12'h050, 4'b0000, 1'b1}
   };

   function automatic string req_of(input logic [3:0] m);
      case (m)
         4'b0000: return "R3";
         4'b1111: return "R4";
         4'b1100: return "R5";
         4'b0110: return "R6";
         4'b0011: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string rq, input logic v, input logic [3:0] cs,
                        input logic e);
      total++;
      // every check also covers R10 through the one-hot expected values
      if (out_valid !== v || cs_out !== cs || mode_err !== e) begin
         bad++;
         $display("FAIL %s: got v=%b cs=%b err=%b expected v=%b cs=%b err=%b",
                  rq, out_valid, cs_out, mode_err, v, cs, e);
      end
   endtask

   task automatic run_req(input logic [3:0] m, input logic [11:0] a,
                          input logic [3:0] cs, input logic e, input string rq);
      @(negedge clk);
      mode      = m;
      req_addr  = AW'(a);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(rq, 1'b1, cs, e);
   endtask

   initial begin
      #200000;
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         start_flat[i*AW +: AW] = AW'(i * 12'h100);
         limit_flat[i*AW +: AW] = AW'((i + 1) * 12'h100);
      end
      ilv_pos = {6'd5, 6'd4};

      repeat (3) @(negedge clk);
      check("R11", 1'b0, 4'b0000, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", 1'b0, 4'b0000, 1'b0);

      for (int k = 0; k < NV; k++) begin
         run_req(VEC[k][20:17], VEC[k][16:5], VEC[k][4:1], VEC[k][0],
                 req_of(VEC[k][20:17]));
      end

      // R1: idle cycle after a request clears everything
      run_req(4'b0101, 12'h000, 4'b0000, 1'b1, "R9");
      @(negedge clk);
      check("R1", 1'b0, 4'b0000, 1'b0);

      // R3: overlapping ranges, lowest rank wins
      start_flat[1*AW +: AW] = AW'(12'h080);
      run_req(4'b0000, 12'h090, 4'b0001, 1'b0, "R3");
      start_flat[1*AW +: AW] = AW'(12'h100);

      // R12: low index beyond width reads 0
      ilv_pos = {6'd5, 6'd40};
      run_req(4'b0011, 12'h010, 4'b0001, 1'b0, "R12");
      ilv_pos = {6'd41, 6'd4};
      run_req(4'b1111, 12'h030, 4'b0010, 1'b0, "R12");
      ilv_pos = {6'd5, 6'd4};

      // R9: a known mode after an error clears the flag
      run_req(4'b1100, 12'h050, 4'b0001, 1'b0, "R9");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule